// File: doc/BRIEF.md
# Conversion Start Trigger Generator

This block decides when a data converter begins a conversion. A 3-bit mode input selects one hardware source, and the block turns events from that source into a single-cycle start pulse. The sources are an edge on an asynchronous external line, with its polarity chosen by the mode, a pen-contact event, a free-running down-counter with a 16-bit reload value, and a continuous mode that restarts after every completed conversion. A software start strobe works in every mode. In mode 0 it is the only way to start a conversion.

The block sits between the converter's control logic and its sequencer. The sequencer consumes `start_o` and reports completion on `conv_done_i`. Channel ordering and analog timing belong to other blocks.

Top module: `conv_trig_gen`

## Requirements
- R1: A high `sw_start_i` sampled at a rising clock edge makes `start_o` high for the following cycle, whatever the mode.
- R2: In mode 0 (`3'b000`) and mode 7 (`3'b111`), the external line, pen events and done strobes produce no pulse on `start_o`.
- R3: Mode 1 (`3'b001`) pulses on a rising external edge. Mode 2 (`3'b010`) pulses on a falling edge. Mode 3 (`3'b011`) pulses on either edge. The line passes through two synchronizing flops, so `start_o` is high in the cycle after the third rising clock edge that follows the change. It is low in the two cycles before that.
- R4: In mode 4 (`3'b100`) with `pen_en_i` high, a `pen_evt_i` pulse sampled at a clock edge makes `start_o` high for the next cycle.
- R5: In mode 4 with `pen_en_i` low, `pen_evt_i` produces no pulse.
- R6: In mode 5 (`3'b101`), a counter loads `period_i` while the mode is inactive. It counts down once per cycle and pulses on zero, reloading at the same time. With P = `period_i`, the n-th cycle after mode 5 is applied carries a pulse exactly when n is a multiple of P+1.
- R7: When mode 6 (`3'b110`) is entered, `start_o` pulses in the first cycle after the entry.
- R8: In mode 6, a `conv_done_i` strobe sampled at a clock edge makes `start_o` high for the next cycle. Without a strobe, no further pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_mode_i | input | 3 | Trigger source select |
| period_i | input | 16 | Reload value of the periodic counter |
| sw_start_i | input | 1 | Software start strobe |
| ext_trig_i | input | 1 | Asynchronous external trigger line |
| pen_evt_i | input | 1 | Pen-contact event pulse |
| pen_en_i | input | 1 | Pen detection enable |
| conv_done_i | input | 1 | Conversion complete strobe |
| start_o | output | 1 | Single-cycle conversion start pulse |

## Verification
The assertions assume that the mode, the period and the enable are static for at least one cycle around the events they judge. The done and pen strobes are expected to be single-cycle pulses. The bench changes the mode only while the other inputs are quiet, and it parks in mode 0 between sweeps. This lets the synchronizer and the counters settle before each pattern starts. Stimulus is driven on the falling clock edge, so the asynchronous line still passes through the synchronizer on its normal path.

// File: rtl/conv_trig_pkg.sv
package conv_trig_pkg;
  typedef enum logic [2:0] {
    TM_SOFT   = 3'd0,
    TM_RISE   = 3'd1,
    TM_FALL   = 3'd2,
    TM_ANY    = 3'd3,
    TM_PEN    = 3'd4,
    TM_PERIOD = 3'd5,
    TM_CONT   = 3'd6,
    TM_RSVD   = 3'd7
  } trig_mode_e;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  AST_EDGE_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |=> !(rise_o && $past(rise_o)) && !(fall_o && $past(fall_o))); // R3
endmodule

// File: rtl/trig_period_timer.sv
module trig_period_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                hit_o
);
  logic [PERIOD_W-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || hit_o)   cnt_q <= period_i;
    else                       cnt_q <= cnt_q - 1'b1;
  end

  AST_PERIOD_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cnt_q == $past(period_i)); // R6
endmodule

// File: rtl/trig_continuous.sv
module trig_continuous (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic done_i,
  output logic hit_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  // one pulse on entry, then one per completed conversion
  assign hit_o = en_i && (!en_q || done_i);

  AST_CONT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_q) |=> en_q); // R7
endmodule

// File: rtl/conv_trig_gen.sv
module conv_trig_gen
  import conv_trig_pkg::*;
#(
  parameter int MODE_W      = 3,
  parameter int PERIOD_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MODE_W-1:0]   trig_mode_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                sw_start_i,
  input  logic                ext_trig_i,
  input  logic                pen_evt_i,
  input  logic                pen_en_i,
  input  logic                conv_done_i,
  output logic                start_o
);
  trig_mode_e mode;
  logic ext_rise, ext_fall, per_hit, cont_hit, hw_hit, start_q;

  assign mode = trig_mode_e'(trig_mode_i);

  trig_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .line_i(ext_trig_i),
    .rise_o(ext_rise), .fall_o(ext_fall)
  );

  trig_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mode == TM_PERIOD),
    .period_i(period_i), .hit_o(per_hit)
  );

  trig_continuous u_cont (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mode == TM_CONT),
    .done_i(conv_done_i), .hit_o(cont_hit)
  );

  always_comb begin
    unique case (mode)
      TM_RISE:   hw_hit = ext_rise;
      TM_FALL:   hw_hit = ext_fall;
      TM_ANY:    hw_hit = ext_rise | ext_fall;
      TM_PEN:    hw_hit = pen_en_i & pen_evt_i;
      TM_PERIOD: hw_hit = per_hit;
      TM_CONT:   hw_hit = cont_hit;
      default:   hw_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= sw_start_i | hw_hit;
  end

  assign start_o = start_q;

  AST_SW_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_start_i |=> start_o); // R1
  AST_SOFT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((trig_mode_i == 3'd0 || trig_mode_i == 3'd7) && !sw_start_i) |=> !start_o); // R2
  AST_PEN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_mode_i == 3'd4 && !pen_en_i && !sw_start_i) |=> !start_o); // R5
  AST_PEN_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_mode_i == 3'd4 && pen_en_i && pen_evt_i) |=> start_o); // R4
  AST_CONT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_mode_i == 3'd6 && conv_done_i) |=> start_o); // R8
endmodule

// File: tb/conv_trig_gen_bench.sv
module conv_trig_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] period = 16'd0;
  logic        sw = 1'b0, ext = 1'b0, pen = 1'b0, pen_en = 1'b0, done = 1'b0;
  logic        start;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  conv_trig_gen u_conv_trig_gen (
    .clk_i(clk), .rst_ni(rst_n), .trig_mode_i(mode), .period_i(period),
    .sw_start_i(sw), .ext_trig_i(ext), .pen_evt_i(pen), .pen_en_i(pen_en),
    .conv_done_i(done), .start_o(start)
  );

  task automatic chk(input logic exp, input string req);
    checks++;
    if (start !== exp) begin
      fails++;
      $display("FAIL %s: start_o=%b expected %b at %0t", req, start, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic park();
    mode = 3'd0; ext = 1'b0; pen = 1'b0; done = 1'b0; sw = 1'b0;
    repeat (5) step();
  endtask

  initial begin
    repeat (3) step();
    chk(1'b0, "reset");
    rst_n = 1'b1;
    step();
    chk(1'b0, "reset");

    // R1: software start in every mode
    for (int m = 0; m < 8; m++) begin
      park();
      period = 16'd1000; pen_en = 1'b0;
      mode = 3'(m);
      repeat (3) step();
      chk(1'b0, "R1 idle");
      sw = 1'b1; step(); sw = 1'b0;
      chk(1'b1, "R1");
      step();
      chk(1'b0, "R1 end");
    end

    // R2: modes 0 and 7 ignore hardware sources
    for (int k = 0; k < 2; k++) begin
      park();
      pen_en = 1'b1;
      mode = (k == 0) ? 3'd0 : 3'd7;
      for (int c = 0; c < 24; c++) begin
        ext = c[2]; pen = c[0]; done = c[1];
        step();
        chk(1'b0, "R2");
      end
    end

    // R3: edge polarity with two-flop latency
    for (int m = 1; m <= 3; m++) begin
      for (int e = 0; e < 2; e++) begin
        logic want;
        park();
        if (e == 1) begin ext = 1'b1; repeat (4) step(); end
        mode = 3'(m);
        step();
        want = (e == 0) ? (m == 1 || m == 3) : (m == 2 || m == 3);
        ext = (e == 0);
        step(); chk(1'b0, "R3 latency");
        step(); chk(1'b0, "R3 latency");
        step(); chk(want, "R3");
        step(); chk(1'b0, "R3 single");
      end
    end

    // R4, R5: pen events gated by enable
    for (int en = 0; en < 2; en++) begin
      park();
      pen_en = en[0];
      mode = 3'd4;
      step();
      pen = 1'b1; step(); pen = 1'b0;
      chk(en[0], en ? "R4" : "R5");
      step();
      chk(1'b0, en ? "R4 single" : "R5");
    end
    pen_en = 1'b0;

    // R6: periodic sweep
    for (int p = 0; p < 12; p++) begin
      park();
      period = 16'(p);
      repeat (2) step();
      mode = 3'd5;
      for (int n = 1; n <= 40; n++) begin
        step();
        chk((n % (p + 1)) == 0, "R6");
      end
    end

    // R7, R8: continuous mode
    for (int r = 0; r < 3; r++) begin
      park();
      mode = 3'd6;
      step(); chk(1'b1, "R7");
      for (int g = 0; g < 4; g++) begin
        repeat (r + 2) begin step(); chk(1'b0, "R8 idle"); end
        done = 1'b1; step(); done = 1'b0;
        chk(1'b1, "R8");
      end
      step(); chk(1'b0, "R8 single");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule